// File: doc/BRIEF.md
# Character I/O and Interrupt Sequencer

This block sits beside the control unit of a small 16-bit accumulator processor. It holds a one-character input buffer with a "character waiting" flag, and a one-character output buffer with a "printer ready" flag. It also holds the interrupt-enable flip-flop and the interrupt-pending flip-flop.

When the control unit executes an I/O-class instruction, it raises `ioExec` for one cycle with the instruction word on `irWord`. An I/O-class instruction is one whose top nibble is F, meaning opcode 7 with the indirect bit set. The block then does four things:
- It decodes the low control bits.
- It moves characters to or from the low byte of the accumulator.
- It requests a program counter increment for skips.
- It ends the instruction by clearing the sequence counter.

The interrupt-pending flip-flop is set between instructions when interrupts are enabled and either flag is up. While that flip-flop is set, the control unit steps the sequence counter through 0, 1 and 2, and the block drives the interrupt cycle:
- It captures the program counter.
- It writes the captured value to memory location 0.
- It makes the program counter land on 1.
- It clears the enable so the handler is not re-entered.

Top module: `pio_irq_top`

## Requirements
- R1: After reset, `inFlag`, `outFlag`, `ienOut` and `intCycle` are all 0.
- R2: A one-cycle `kbdStrobe` stores `kbdData` in the input buffer, and `inFlag` is 1 from the next cycle.
- R3: While `ioExec` is high with word 16'hF800, `accLoadEn` is 1 and `accLoadData` equals the input buffer. From the next cycle `inFlag` is 0, unless `kbdStrobe` was high in the same cycle, in which case `inFlag` stays 1 and the new character is stored.
- R4: A one-cycle `prnDone` makes `outFlag` 1 from the next cycle.
- R5: Word 16'hF400 under `ioExec` loads `accLow` into the output buffer. In the next cycle `prnStrobe` is 1 for exactly one cycle, `prnData` equals that byte and `outFlag` is 0.
- R6: Word 16'hF200 under `ioExec` gives `pcInc` = `inFlag`. Word 16'hF100 gives `pcInc` = `outFlag`. Every I/O-class word under `ioExec` asserts `scClr` in that cycle.
- R7: Word 16'hF080 sets `ienOut` to 1 from the next cycle, and word 16'hF040 clears it.
- R8: `intCycle` becomes 1 after a clock edge at which `ienOut` is 1, `inFlag` or `outFlag` is 1, `scIn` is greater than 2 and `ioExec` is low. It never becomes 1 while `scIn` is 0, 1 or 2.
- R9: While `intCycle` is 1, the three steps behave as follows.
  - With `scIn` = 0, `arClr` is 1 and the current `pcIn` is captured.
  - With `scIn` = 1, `memWe` is 1, `memAddr` is 0, `memWData` is the captured PC zero-extended, and `pcClr` is 1.
  - With `scIn` = 2, `pcInc` and `scClr` are 1, and from the next cycle `intCycle` and `ienOut` are 0.
- R10: An `ioExec` word whose top nibble is not F has no effect: `accLoadEn`, `pcInc` and `scClr` stay 0, and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioExec | input | 1 | Execute-step pulse for the word on irWord |
| irWord | input | 16 | Instruction word |
| scIn | input | 4 | Current sequence counter value |
| accLow | input | 8 | Accumulator low byte |
| pcIn | input | 12 | Current program counter |
| kbdStrobe | input | 1 | Keyboard character valid |
| kbdData | input | 8 | Keyboard character |
| prnDone | input | 1 | Printer finished previous character |
| accLoadEn | output | 1 | Load accLoadData into accumulator low byte |
| accLoadData | output | 8 | Input buffer contents |
| pcInc | output | 1 | Increment program counter |
| pcClr | output | 1 | Clear program counter |
| arClr | output | 1 | Clear address register |
| scClr | output | 1 | Clear sequence counter |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 12 | Memory write address |
| memWData | output | 16 | Memory write data |
| prnStrobe | output | 1 | New character on prnData |
| prnData | output | 8 | Output buffer contents |
| inFlag | output | 1 | Input character waiting |
| outFlag | output | 1 | Printer ready |
| ienOut | output | 1 | Interrupt enable state |
| intCycle | output | 1 | Interrupt cycle pending or running |

## Verification
The hardest situation to reach is the interrupt gating. Enable and a raised flag must be present while the sequence counter sits inside steps 0 to 2, and no interrupt may start then. The bench reaches it by holding `scIn` at 1 while it executes the enable instruction with a character waiting, and then walking `scIn` through 0 and 2. Only then does it release `scIn` to 3 and expect the interrupt cycle on the next edge. The save step is checked with a distinctive `pcIn` captured at step 0, so a stale or wrong capture shows up in `memWData`.

// File: rtl/pio_irq_pkg.sv
package pio_irq_pkg;
  typedef struct packed {
    logic loadIn;
    logic clrFgi;
    logic loadOut;
    logic clrFgo;
    logic setIen;
    logic clrIen;
    logic setR;
    logic clrR;
    logic saveTr;
  } ioStrobes_t;
endpackage

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl
  import pio_irq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SC_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioExec,
  input  logic [WORD_W-1:0] irWord,
  input  logic [SC_W-1:0]   scIn,
  input  logic              fgiFlag,
  input  logic              fgoFlag,
  input  logic              ienFlag,
  input  logic              rFlag,
  output ioStrobes_t        strb,
  output logic              accLoadEn,
  output logic              pcInc,
  output logic              pcClr,
  output logic              arClr,
  output logic              memWe,
  output logic              scClr
);
  localparam int TOP     = WORD_W - 1;
  localparam int BIT_INP = WORD_W - 5;
  localparam int BIT_OUT = WORD_W - 6;
  localparam int BIT_SKI = WORD_W - 7;
  localparam int BIT_SKO = WORD_W - 8;
  localparam int BIT_ION = WORD_W - 9;
  localparam int BIT_IOF = WORD_W - 10;
  localparam logic [SC_W-1:0] STEP0 = SC_W'(0);
  localparam logic [SC_W-1:0] STEP1 = SC_W'(1);
  localparam logic [SC_W-1:0] STEP2 = SC_W'(2);

  logic isIo, stepT0, stepT1, stepT2, skipHit;

  always_comb begin
    isIo    = ioExec && (irWord[TOP -: 4] == 4'hF);
    stepT0  = rFlag && (scIn == STEP0);
    stepT1  = rFlag && (scIn == STEP1);
    stepT2  = rFlag && (scIn == STEP2);
    skipHit = isIo && ((irWord[BIT_SKI] && fgiFlag) || (irWord[BIT_SKO] && fgoFlag));

    strb.loadIn  = isIo && irWord[BIT_INP];
    strb.clrFgi  = isIo && irWord[BIT_INP];
    strb.loadOut = isIo && irWord[BIT_OUT];
    strb.clrFgo  = isIo && irWord[BIT_OUT];
    strb.setIen  = isIo && irWord[BIT_ION];
    strb.clrIen  = (isIo && irWord[BIT_IOF]) || stepT2;
    strb.setR    = ienFlag && (fgiFlag || fgoFlag) && !rFlag && !isIo && (scIn > STEP2);
    strb.clrR    = stepT2;
    strb.saveTr  = stepT0;

    accLoadEn = strb.loadIn;
    pcInc     = skipHit || stepT2;
    pcClr     = stepT1;
    arClr     = stepT0;
    memWe     = stepT1;
    scClr     = isIo || stepT2;
  end

  // R9
  ien_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rFlag && scIn == STEP2) |=> (!ienFlag && !rFlag));

  // R8
  no_early_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rFlag && scIn <= STEP2) |=> !rFlag);
endmodule

// File: rtl/pio_irq_regs.sv
module pio_irq_regs
  import pio_irq_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobes_t        strb,
  input  logic              kbdStrobe,
  input  logic [CHAR_W-1:0] kbdData,
  input  logic              prnDone,
  input  logic [CHAR_W-1:0] accLow,
  input  logic [ADDR_W-1:0] pcIn,
  output logic [CHAR_W-1:0] inBuf,
  output logic [CHAR_W-1:0] outBuf,
  output logic              prnStrobe,
  output logic              fgiReg,
  output logic              fgoReg,
  output logic              ienReg,
  output logic              rReg,
  output logic [WORD_W-1:0] saveWord
);
  localparam int PAD_W = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] trReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBuf     <= '0;
      outBuf    <= '0;
      prnStrobe <= 1'b0;
      fgiReg    <= 1'b0;
      fgoReg    <= 1'b0;
      ienReg    <= 1'b0;
      rReg      <= 1'b0;
      trReg     <= '0;
    end else begin
      prnStrobe <= strb.loadOut;
      if (kbdStrobe) begin
        inBuf  <= kbdData;
        fgiReg <= 1'b1;
      end else if (strb.clrFgi) begin
        fgiReg <= 1'b0;
      end
      if (strb.loadOut) outBuf <= accLow;
      if (prnDone) fgoReg <= 1'b1;
      else if (strb.clrFgo) fgoReg <= 1'b0;
      if (strb.clrIen) ienReg <= 1'b0;
      else if (strb.setIen) ienReg <= 1'b1;
      if (strb.clrR) rReg <= 1'b0;
      else if (strb.setR) rReg <= 1'b1;
      if (strb.saveTr) trReg <= pcIn;
    end
  end

  assign saveWord = {{PAD_W{1'b0}}, trReg};

  // R2
  fgi_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(kbdStrobe) |-> fgiReg);

  // R4
  fgo_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fgoReg) |-> $past(prnDone));

  // R8
  r_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rReg) |-> $past(ienReg && (fgiReg || fgoReg)));
endmodule

// File: rtl/pio_irq_top.sv
module pio_irq_top
  import pio_irq_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12,
  parameter int CHAR_W = 8,
  parameter int SC_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioExec,
  input  logic [WORD_W-1:0] irWord,
  input  logic [SC_W-1:0]   scIn,
  input  logic [CHAR_W-1:0] accLow,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              kbdStrobe,
  input  logic [CHAR_W-1:0] kbdData,
  input  logic              prnDone,
  output logic              accLoadEn,
  output logic [CHAR_W-1:0] accLoadData,
  output logic              pcInc,
  output logic              pcClr,
  output logic              arClr,
  output logic              scClr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic              prnStrobe,
  output logic [CHAR_W-1:0] prnData,
  output logic              inFlag,
  output logic              outFlag,
  output logic              ienOut,
  output logic              intCycle
);
  localparam logic [ADDR_W-1:0] SAVE_ADDR = '0;

  ioStrobes_t strb;
  logic fgiReg, fgoReg, ienReg, rReg;

  pio_irq_ctrl #(.WORD_W(WORD_W), .SC_W(SC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioExec(ioExec), .irWord(irWord), .scIn(scIn),
    .fgiFlag(fgiReg), .fgoFlag(fgoReg), .ienFlag(ienReg), .rFlag(rReg),
    .strb(strb), .accLoadEn(accLoadEn), .pcInc(pcInc), .pcClr(pcClr),
    .arClr(arClr), .memWe(memWe), .scClr(scClr)
  );

  pio_irq_regs #(.CHAR_W(CHAR_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .kbdStrobe(kbdStrobe), .kbdData(kbdData),
    .prnDone(prnDone), .accLow(accLow), .pcIn(pcIn), .inBuf(accLoadData),
    .outBuf(prnData), .prnStrobe(prnStrobe), .fgiReg(fgiReg), .fgoReg(fgoReg),
    .ienReg(ienReg), .rReg(rReg), .saveWord(memWData)
  );

  assign memAddr  = SAVE_ADDR;
  assign inFlag   = fgiReg;
  assign outFlag  = fgoReg;
  assign ienOut   = ienReg;
  assign intCycle = rReg;

  // R9
  save_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWData == WORD_W'($past(pcIn))));
endmodule

// File: tb/pio_irq_top_tb.sv
module pio_irq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioExec = 1'b0;
  logic [15:0] irWord = '0;
  logic [3:0]  scIn = 4'd3;
  logic [7:0]  accLow = '0;
  logic [11:0] pcIn = '0;
  logic        kbdStrobe = 1'b0;
  logic [7:0]  kbdData = '0;
  logic        prnDone = 1'b0;
  logic        accLoadEn, pcInc, pcClr, arClr, scClr, memWe, prnStrobe;
  logic        inFlag, outFlag, ienOut, intCycle;
  logic [7:0]  accLoadData, prnData;
  logic [11:0] memAddr;
  logic [15:0] memWData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pio_irq_top u_dut (
    .clk(clk), .rstN(rstN), .ioExec(ioExec), .irWord(irWord), .scIn(scIn),
    .accLow(accLow), .pcIn(pcIn), .kbdStrobe(kbdStrobe), .kbdData(kbdData),
    .prnDone(prnDone), .accLoadEn(accLoadEn), .accLoadData(accLoadData),
    .pcInc(pcInc), .pcClr(pcClr), .arClr(arClr), .scClr(scClr), .memWe(memWe),
    .memAddr(memAddr), .memWData(memWData), .prnStrobe(prnStrobe),
    .prnData(prnData), .inFlag(inFlag), .outFlag(outFlag), .ienOut(ienOut),
    .intCycle(intCycle)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic startExec(input logic [15:0] w);
    irWord = w;
    ioExec = 1'b1;
    #1;
  endtask

  task automatic endExec();
    tick();
    ioExec = 1'b0;
    irWord = '0;
  endtask

  task automatic kbdPut(input logic [7:0] c);
    kbdData = c;
    kbdStrobe = 1'b1;
    tick();
    kbdStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual expired expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    rstN = 1'b1;
    #1;
    check("R1 inFlag", inFlag, 0);
    check("R1 outFlag", outFlag, 0);
    check("R1 ienOut", ienOut, 0);
    check("R1 intCycle", intCycle, 0);

    for (int v = 0; v < 256; v++) begin
      kbdPut(8'(v));
      check("R2 inFlag set", inFlag, 1);
      startExec(16'hF800);
      check("R3 accLoadEn", accLoadEn, 1);
      check("R3 accLoadData", accLoadData, v);
      check("R6 scClr on io", scClr, 1);
      endExec();
      check("R3 inFlag cleared", inFlag, 0);
    end

    for (int v = 0; v < 256; v++) begin
      prnDone = 1'b1;
      tick();
      prnDone = 1'b0;
      check("R4 outFlag set", outFlag, 1);
      accLow = 8'(255 - v);
      startExec(16'hF400);
      endExec();
      check("R5 prnStrobe", prnStrobe, 1);
      check("R5 prnData", prnData, 255 - v);
      check("R5 outFlag cleared", outFlag, 0);
      tick();
      check("R5 prnStrobe single", prnStrobe, 0);
    end

    startExec(16'hF200);
    check("R6 SKI no char", pcInc, 0);
    endExec();
    kbdPut(8'h41);
    startExec(16'hF200);
    check("R6 SKI char", pcInc, 1);
    endExec();
    startExec(16'hF100);
    check("R6 SKO not ready", pcInc, 0);
    endExec();
    prnDone = 1'b1;
    tick();
    prnDone = 1'b0;
    startExec(16'hF100);
    check("R6 SKO ready", pcInc, 1);
    endExec();

    startExec(16'h7800);
    check("R10 accLoadEn", accLoadEn, 0);
    check("R10 scClr", scClr, 0);
    check("R10 pcInc", pcInc, 0);
    endExec();
    startExec(16'hE400);
    check("R10 scClr high nibble E", scClr, 0);
    endExec();
    check("R10 inFlag kept", inFlag, 1);
    check("R10 outFlag kept", outFlag, 1);
    check("R10 prnStrobe", prnStrobe, 0);

    kbdData = 8'h5C;
    kbdStrobe = 1'b1;
    startExec(16'hF800);
    check("R3 simultaneous old char", accLoadData, 8'h41);
    endExec();
    kbdStrobe = 1'b0;
    check("R3 simultaneous flag kept", inFlag, 1);
    startExec(16'hF800);
    check("R3 simultaneous new char", accLoadData, 8'h5C);
    endExec();

    startExec(16'hF080);
    endExec();
    check("R7 ion", ienOut, 1);
    startExec(16'hF040);
    endExec();
    check("R7 iof", ienOut, 0);

    accLow = 8'h00;
    startExec(16'hF400);
    endExec();
    kbdPut(8'h33);
    scIn = 4'd1;
    startExec(16'hF080);
    endExec();
    check("R7 ion again", ienOut, 1);
    tick();
    check("R8 held at step1", intCycle, 0);
    scIn = 4'd0;
    tick();
    check("R8 held at step0", intCycle, 0);
    scIn = 4'd2;
    tick();
    check("R8 held at step2", intCycle, 0);
    scIn = 4'd3;
    tick();
    check("R8 taken", intCycle, 1);

    scIn = 4'd0;
    pcIn = 12'h5A3;
    #1;
    check("R9 T0 arClr", arClr, 1);
    check("R9 T0 memWe", memWe, 0);
    tick();
    scIn = 4'd1;
    pcIn = 12'h111;
    #1;
    check("R9 T1 memWe", memWe, 1);
    check("R9 T1 memAddr", memAddr, 0);
    check("R9 T1 memWData", memWData, 16'h05A3);
    check("R9 T1 pcClr", pcClr, 1);
    check("R9 T1 pcInc", pcInc, 0);
    tick();
    scIn = 4'd2;
    #1;
    check("R9 T2 pcInc", pcInc, 1);
    check("R9 T2 scClr", scClr, 1);
    check("R9 T2 memWe", memWe, 0);
    tick();
    scIn = 4'd3;
    #1;
    check("R9 intCycle cleared", intCycle, 0);
    check("R9 ien cleared", ienOut, 0);
    tick();
    tick();
    check("R8 no reentry", intCycle, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule